// File: doc/BRIEF.md
# Majority-Flag Serial Flip-Position Link

This block carries a 7-bit word across a narrow 4-line link built to limit worst-case coupling between neighbouring lines. The sending side finds which value holds the majority in the word and drives it on a single flag line. On the three remaining lines it then sends, one per clock, the 3-bit position of each bit that disagrees with that majority. A word therefore costs one to three link cycles, depending on how many minority bits it holds.

The receiving side fills a fresh word with the flag value and toggles each position it receives. The last beat of a word carries an end strobe, and the rebuilt word is presented on a valid/ready output. Both sides sit in one module, and the link lines are brought out as ports so that the traffic on them can be observed. The input side takes words through a valid/ready handshake and refuses new words while the current one is still being serialised.

Top module: `flipidx_link`

## Requirements
- R1: During each word on the link, `lk_flag` is 1 when the word has four or more ones and 0 otherwise.
- R2: Each link beat carries on `lk_idx` the bit position (0 to 6) of one bit that differs from the flag. Positions go out in strictly ascending order, and the word uses exactly as many beats as it has such bits.
- R3: A word whose seven bits are all equal uses exactly one beat, with `lk_idx` = 3'b111 and `lk_last` = 1. The code 3'b111 never appears on any other beat.
- R4: `lk_last` is 1 on the final beat of each word and 0 on every earlier beat.
- R5: `lk_flag` does not change between beats of one word.
- R6: `in_ready` is 0 from the cycle after a word is accepted until that word's final beat has left the link, and 1 at all other times. The first beat appears on the link in the cycle after acceptance.
- R7: In the cycle after the final beat of a word leaves the link, `out_valid` is 1 and `out_word` equals the accepted input word.
- R8: While `out_valid` is 1 and `out_ready` is 0, `out_word` holds its value and the link beat on display does not advance.
- R9: After reset, `in_ready` is 1 and `lk_valid` and `out_valid` are 0.
- R10: Decoded words leave in the order in which they were accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input word offered |
| in_ready | output | 1 | Input word can be taken |
| in_word | input | 7 | Word to send |
| lk_valid | output | 1 | A link beat is on display |
| lk_flag | output | 1 | Majority value of the word in flight |
| lk_idx | output | 3 | Position of one minority bit, or 3'b111 for none |
| lk_last | output | 1 | Final beat of the word |
| out_valid | output | 1 | Decoded word available |
| out_ready | input | 1 | Consumer takes the decoded word |
| out_word | output | 7 | Decoded word |

## Verification
The assertions watch, on every cycle, the link invariants: a constant flag within a word, strictly rising positions, the "none" code only on a final beat, the link starting right after acceptance, the output appearing right after a final beat, and output and link holding under back-pressure. Only the bench's reference model can show that the flag really is the majority, that the set of positions is exactly the set of minority bits, and that the rebuilt word and the order of words match the input. The scenarios cover uniform words, words with one, two and three minority bits, back-to-back traffic and random output stalls.

// File: rtl/flipidx_link.sv
module flipidx_link #(
  parameter int W = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_word,
  output logic         lk_valid,
  output logic         lk_flag,
  output logic [2:0]   lk_idx,
  output logic         lk_last,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_word
);
  localparam int CW = $clog2(W + 1);
  localparam logic [2:0] NONE = 3'b111;

  logic         busy, flag_q, dec_first, ov;
  logic [W-1:0] pend, acc, out_q, mask, base, hit, nxt;
  logic [CW-1:0] ones, pend_cnt;
  logic [2:0]   low;
  logic         maj, accept, stall, adv;

  always_comb begin
    ones = '0;
    pend_cnt = '0;
    low = NONE;
    for (int i = 0; i < W; i++) begin
      ones = ones + CW'(in_word[i]);
      pend_cnt = pend_cnt + CW'(pend[i]);
    end
    for (int i = W - 1; i >= 0; i--)
      if (pend[i]) low = 3'(i);
  end

  assign maj    = ones > CW'(W / 2);
  assign mask   = in_word ^ {W{maj}};
  assign accept = in_valid && !busy;
  assign stall  = ov && !out_ready;
  assign adv    = busy && !stall;

  assign in_ready = !busy;
  assign lk_valid = busy;
  assign lk_flag  = flag_q;
  assign lk_idx   = low;
  assign lk_last  = pend_cnt <= CW'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      pend   <= '0;
      flag_q <= 1'b0;
    end else if (accept) begin
      busy   <= 1'b1;
      pend   <= mask;
      flag_q <= maj;
    end else if (adv) begin
      pend <= pend & (pend - 1'b1);
      if (lk_last) busy <= 1'b0;
    end
  end

  assign base = dec_first ? {W{flag_q}} : acc;
  assign hit  = (low == NONE) ? '0 : ({{(W-1){1'b0}}, 1'b1} << low);
  assign nxt  = base ^ hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc       <= '0;
      out_q     <= '0;
      ov        <= 1'b0;
      dec_first <= 1'b1;
    end else begin
      if (ov && out_ready) ov <= 1'b0;
      if (adv) begin
        if (lk_last) begin
          out_q     <= nxt;
          ov        <= 1'b1;
          dec_first <= 1'b1;
        end else begin
          acc       <= nxt;
          dec_first <= 1'b0;
        end
      end
    end
  end

  assign out_valid = ov;
  assign out_word  = out_q;
endmodule

// File: rtl/flipidx_link_chk.sv
module flipidx_link_chk #(
  parameter int W = 7
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic         in_ready,
  input logic [W-1:0] in_word,
  input logic         lk_valid,
  input logic         lk_flag,
  input logic [2:0]   lk_idx,
  input logic         lk_last,
  input logic         out_valid,
  input logic         out_ready,
  input logic [W-1:0] out_word
);
  assert_flag_steady_R5: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid && !lk_last && !(out_valid && !out_ready) |=> lk_flag == $past(lk_flag));

  assert_idx_rising_R2: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid && !lk_last && !(out_valid && !out_ready) |=> lk_valid && (lk_idx > $past(lk_idx)));

  assert_none_is_last_R3: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid && lk_idx == 3'b111 |-> lk_last);

  assert_start_after_accept_R6: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> lk_valid && !in_ready);

  assert_out_after_last_R7: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid && lk_last && !(out_valid && !out_ready) |=> out_valid && !lk_valid);

  assert_out_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_word));

  assert_link_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready && lk_valid |=> lk_valid && $stable(lk_idx) && $stable(lk_last));
endmodule

bind flipidx_link flipidx_link_chk #(.W(W)) chk_i (.*);

// File: tb/flipidx_link_tb_top.sv
module flipidx_link_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, out_ready = 1'b1;
  logic [6:0] in_word = '0;
  logic in_ready, lk_valid, lk_flag, lk_last, out_valid;
  logic [2:0] lk_idx;
  logic [6:0] out_word;

  flipidx_link dut_i (.*);

  always #2 clk = ~clk;

  int errors = 0, checks = 0, cycles = 0;
  bit stall_mode = 0, done = 0;
  logic [4:0] beatq[$];
  logic [6:0] wordq[$];
  logic m_ov = 0;
  logic [6:0] m_ow = '0;

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      beatq.delete(); wordq.delete(); m_ov = 0;
    end else begin
      int n0;
      logic [4:0] b;
      bit adv;
      n0 = beatq.size();
      adv = (n0 > 0) && !(m_ov && !out_ready);
      if (m_ov && out_ready) m_ov = 0;
      if (adv) begin
        b = beatq.pop_front();
        if (b[0]) begin m_ov = 1; m_ow = wordq.pop_front(); end
      end
      if (in_valid && n0 == 0) begin
        bit maj;
        logic [6:0] m;
        int k, n;
        maj = $countones(in_word) >= 4;
        m = in_word ^ {7{maj}};
        n = $countones(m);
        k = 0;
        if (n == 0) beatq.push_back({maj, 3'b111, 1'b1});
        for (int i = 0; i < 7; i++)
          if (m[i]) begin k++; beatq.push_back({maj, 3'(i), k == n}); end
        wordq.push_back(in_word);
      end
    end
  end

  always @(negedge clk) begin
    cycles++;
    if (rst_n && !done) begin
      chk(in_ready == (beatq.size() == 0), "R6 in_ready", in_ready, beatq.size() == 0);
      chk(lk_valid == (beatq.size() > 0), "R6 lk_valid", lk_valid, beatq.size() > 0);
      if (beatq.size() > 0 && lk_valid) begin
        chk(lk_flag == beatq[0][4], "R1 R5 flag", lk_flag, beatq[0][4]);
        chk(lk_idx == beatq[0][3:1], "R2 R3 idx", lk_idx, beatq[0][3:1]);
        chk(lk_last == beatq[0][0], "R4 last", lk_last, beatq[0][0]);
      end
      chk(out_valid == m_ov, "R7 R8 out_valid", out_valid, m_ov);
      if (m_ov && out_valid) chk(out_word == m_ow, "R7 R10 out_word", out_word, m_ow);
    end
    if (stall_mode) out_ready = ($urandom % 3) != 0;
  end

  task automatic send(input logic [6:0] w);
    @(negedge clk);
    in_valid = 1'b1; in_word = w;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        chk(in_ready && !lk_valid && !out_valid, "R9 reset state",
            {in_ready, lk_valid, out_valid}, 3'b100);
        rst_n = 1'b1;
        send(7'b0000000); send(7'b1111111);            // R3
        send(7'b0000100); send(7'b1011111);            // one minority bit
        send(7'b1000001); send(7'b0110111);            // two
        send(7'b1010100); send(7'b0101011);            // three, R2 order
        send(7'b1001001); send(7'b0111000);
        for (int i = 0; i < 60; i++) send(7'($urandom));
        stall_mode = 1;                                // R8
        for (int i = 0; i < 80; i++) send(7'($urandom));
        stall_mode = 0; out_ready = 1'b1;
        repeat (10) @(negedge clk);
        chk(beatq.size() == 0 && wordq.size() == 0, "R10 all words drained",
            wordq.size(), 0);
      end
      begin
        while (cycles < 100000) @(negedge clk);
        chk(0, "watchdog expired", cycles, 100000);
      end
    join_any
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule